// File: doc/BRIEF.md
# Interline CCD Drive Timing Generator

This block produces the digital control timing for a field-readout interline CCD imager in a 625-line interlaced system. One system clock is divided into pixel periods of a fixed number of phases. A pixel counter and a line-within-field counter are the only state in the timing path. All drive outputs are decoded from these two counters. The outputs are the two complementary horizontal shift clocks, a per-pixel reset gate pulse, the horizontal blanking flag, line and field sync strobes, four vertical transfer phase levels, two readout gate pulses and the substrate drain pulse of the electronic shutter. The outputs are logic-level controls only. They go to an external level shifter and vertical driver.

A line holds a blanking interval, then dummy horizontal bits, then front optical-black pixels, then effective pixels, then rear optical-black pixels. A field holds vertical blanking lines, then front optical-black lines, then effective lines, then rear optical-black lines. The even field has one extra dummy line in front of its front optical-black lines, so it is one line longer than the odd field. The two field lengths add up to the frame length. At the readout line of each field, charge moves from the photosites through the gates on phases 1 and 3. The two gates fire in opposite order in the two fields, which shifts the row pairing by one row. Storage time is shortened by substrate drain pulses in the blanking of early lines. The last draining line comes from an input that is sampled once per field.

Top module: `ccd_timing_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the generator goes to phase 0, pixel 0, line 1 of the odd field, with the latched shutter line cleared. Just after reset, `fld`=0, `vd`=1, `hd`=1, `rg`=1, `h1`=1, `h2`=0 and `hblank`=1.
- R2: Each pixel lasts `PH_PER_PIX` clocks. `h1` is high in the first half of the pixel's phases and `h2` in the second half, so the two are always complementary. `rg` is high only in phase 0. These clocks run without a break, including through blanking.
- R3: A line has `H_BLANK+H_DUMMY+H_OBF+H_EFF+H_OBR` pixels, numbered from 0. `hblank` is high for pixels 0 to `H_BLANK-1`. `pix_act` is high only for the `H_EFF` pixels that start at pixel `H_BLANK+H_DUMMY+H_OBF`.
- R4: `hd` is high for the whole of pixel 0 of every line. `vd` is high for the whole of line 1 of every field.
- R5: The odd field (`fld`=0) has `V_BLANK+V_OBF+V_EFF+V_OBR` lines and the even field (`fld`=1) has one more. `fld` changes only when line 1 of a new field begins.
- R6: `line_act` is high for `V_EFF` lines. In the odd field these start at line `V_BLANK+V_OBF+1`. In the even field they start one line later, because of the dummy line.
- R7: On every line except `READ_LINE`, `v_phase` steps through 8 patterns of `VX_STEP` pixels each, starting at pixel `VX_START`. `v_phase[0]` is phase 1. In step k, phases k/2 and k/2+1 (mod 4) are high, and phase k/2+2 is also high when k is odd. Outside this window `v_phase` holds the idle pattern 4'b0011.
- R8: On line `READ_LINE`, `v_phase` stays at the idle pattern for the whole line. There are two readout windows of `RD_W` pixels each, starting at `RD_A` and at `RD_B`. In the odd field, `read_p1` fires in the first window and `read_p3` in the second. In the even field the order is reversed. The two readout gates are never high together.
- R9: `sub_pulse` is high for pixels `SUB_START` to `SUB_START+SUB_W-1` on each line L where `READ_LINE` < L < S. S is the latched shutter line, and S = 0 gives no pulses.
- R10: The latched shutter line takes the value of `shutter_line` only at the step into line 1 of a new field. A change in the middle of a field acts only from the next field on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `PH_PER_PIX` clocks per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| shutter_line | input | LW | Requested shutter line; draining stops before this line (0 = off) |
| h1 | output | 1 | Horizontal shift clock, first half of each pixel |
| h2 | output | 1 | Horizontal shift clock, second half of each pixel |
| rg | output | 1 | Reset gate pulse, phase 0 of each pixel |
| hblank | output | 1 | Horizontal blanking flag |
| hd | output | 1 | Line-drive strobe, pixel 0 |
| vd | output | 1 | Field-drive strobe, line 1 |
| fld | output | 1 | Field flag, 0 odd, 1 even |
| pix_act | output | 1 | Effective-pixel qualifier |
| line_act | output | 1 | Effective-line qualifier |
| v_phase | output | 4 | Vertical transfer phase levels, bit 0 = phase 1 |
| read_p1 | output | 1 | Readout gate on phase 1 |
| read_p3 | output | 1 | Readout gate on phase 3 |
| sub_pulse | output | 1 | Substrate drain pulse |

## Verification
A behavioural model follows pixel, line, field and latched shutter with plain integers. Its expected outputs are compared on every clock through several whole frames. Three shutter settings are used. Zero tells apart a block that drains with no request. A value inside the field checks the upper bound of draining. A value larger than the field length checks that draining runs to the field end. Shutter changes land in the middle of a field, so a design that latches at once and not at the field boundary shows up. A reset in the middle of a run checks that the latched value clears and that the odd field restarts. The even field is passed through repeatedly, which separates the swapped readout order and the one-line shift of the active lines from the odd-field behaviour.

// File: rtl/ccdtg_pkg.sv
// Shared types and helpers for the CCD timing generator.
// Assumes: vertical phases are indexed 0..3 for phase 1..4.
package ccdtg_pkg;

    typedef enum logic {
        FLD_ODD  = 1'b0,
        FLD_EVEN = 1'b1
    } fld_t;

    // Four-phase overlap pattern for step k of an 8-step vertical shift.
    function automatic logic [3:0] vx_pattern(input logic [2:0] k);
        logic [1:0] b;
        logic [3:0] p;
        b = k[2:1];
        p = 4'b0000;
        p[b] = 1'b1;
        p[b + 2'd1] = 1'b1;
        if (k[0]) p[b + 2'd2] = 1'b1;
        return p;
    endfunction

endpackage

// File: rtl/ccdtg_hcount.sv
// Horizontal timing: sub-pixel phase and pixel counters. The shift
// clocks, reset gate and horizontal flags are decoded from them.
// Assumes PH_PER_PIX >= 2 and H_BLANK >= 1. The clocks run in every pixel.
module ccdtg_hcount #(
    parameter int PH_PER_PIX = 4,
    parameter int LINE_PIX   = 864,
    parameter int H_BLANK    = 47,
    parameter int ACT_FIRST  = 72,
    parameter int H_EFF      = 752,
    parameter int PW         = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] pix,
    output logic          line_end,
    output logic          h1,
    output logic          h2,
    output logic          rg,
    output logic          hblank,
    output logic          hd,
    output logic          pix_act
);
    localparam int PHW = (PH_PER_PIX > 2) ? $clog2(PH_PER_PIX) : 1;
    localparam logic [PHW-1:0] PH_LAST  = PHW'(PH_PER_PIX - 1);
    localparam logic [PHW-1:0] PH_HALF  = PHW'(PH_PER_PIX / 2);
    localparam logic [PW-1:0]  PIX_LAST = PW'(LINE_PIX - 1);
    localparam logic [PW-1:0]  HB_END   = PW'(H_BLANK);
    localparam logic [PW-1:0]  ACT_LO   = PW'(ACT_FIRST);
    localparam logic [PW-1:0]  ACT_HI   = PW'(ACT_FIRST + H_EFF - 1);

    logic [PHW-1:0] phase;

    // Phase counter, and the pixel counter that it carries into.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            pix   <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
            pix   <= (pix == PIX_LAST) ? '0 : pix + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Decode of the clocks and flags from the counters.
    always_comb begin
        line_end = (phase == PH_LAST) && (pix == PIX_LAST);
        h1       = (phase < PH_HALF);
        h2       = (phase >= PH_HALF);
        rg       = (phase == '0);
        hblank   = (pix < HB_END);
        hd       = (pix == '0);
        pix_act  = (pix >= ACT_LO) && (pix <= ACT_HI);
    end

    a_r2_pixel_wraps_on_last_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (pix != $past(pix)) |-> $past(phase == PH_LAST));

    a_r2_reset_gate_in_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        rg |-> (h1 && !h2));

endmodule

// File: rtl/ccdtg_vcount.sv
// Vertical timing: line-within-field counter, field flag and the
// shutter line latched at each field start.
// Assumes the even field is one line (the dummy line) longer than the odd field.
module ccdtg_vcount
    import ccdtg_pkg::*;
#(
    parameter int LINES_ODD = 312,
    parameter int ACT_FIRST = 20,
    parameter int V_EFF     = 291,
    parameter int LW        = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic [LW-1:0] shutter_line,
    output logic [LW-1:0] line,
    output logic          fld,
    output logic [LW-1:0] shut_q,
    output logic          vd,
    output logic          line_act
);
    localparam logic [LW-1:0] LAST_ODD  = LW'(LINES_ODD);
    localparam logic [LW-1:0] LAST_EVEN = LW'(LINES_ODD + 1);
    localparam logic [LW-1:0] ACT_LO    = LW'(ACT_FIRST);
    localparam logic [LW-1:0] ACT_SPAN  = LW'(V_EFF - 1);

    fld_t          fld_q;
    logic [LW-1:0] last_line;
    logic [LW-1:0] act_lo;

    // Line and field counters; the shutter value is latched at the field turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line   <= LW'(1);
            fld_q  <= FLD_ODD;
            shut_q <= '0;
        end else if (line_end) begin
            if (line == last_line) begin
                line   <= LW'(1);
                fld_q  <= (fld_q == FLD_ODD) ? FLD_EVEN : FLD_ODD;
                shut_q <= shutter_line;
            end else begin
                line <= line + 1'b1;
            end
        end
    end

    // Decode of the field length, sync strobe and active lines.
    always_comb begin
        fld       = (fld_q == FLD_EVEN);
        last_line = fld ? LAST_EVEN : LAST_ODD;
        act_lo    = ACT_LO + LW'(fld);
        vd        = (line == LW'(1));
        line_act  = (line >= act_lo) && (line <= act_lo + ACT_SPAN);
    end

    a_r5_field_turns_at_line_one: assert property (@(posedge clk) disable iff (!rst_n)
        (fld != $past(fld)) |-> (line == LW'(1)));

    a_r10_shutter_moves_only_at_field_start: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_q != $past(shut_q)) |-> (line == LW'(1)));

endmodule

// File: rtl/ccdtg_vdrive.sv
// Vertical drive decode: four-phase transfer levels, field-ordered readout
// gates and shutter substrate pulses, from the pixel, line and field state.
// Assumes all pixel windows lie inside horizontal blanking.
module ccdtg_vdrive
    import ccdtg_pkg::*;
#(
    parameter int PW        = 10,
    parameter int LW        = 9,
    parameter int READ_LINE = 4,
    parameter int VX_START  = 4,
    parameter int VX_STEP   = 4,
    parameter int RD_A      = 8,
    parameter int RD_B      = 24,
    parameter int RD_W      = 8,
    parameter int SUB_START = 38,
    parameter int SUB_W     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pix,
    input  logic [LW-1:0] line,
    input  logic          fld,
    input  logic [LW-1:0] shut_q,
    output logic [3:0]    v_phase,
    output logic          read_p1,
    output logic          read_p3,
    output logic          sub_pulse
);
    localparam int NSTEP = 8;
    localparam logic [LW-1:0] RD_LINE = LW'(READ_LINE);
    localparam logic [PW-1:0] A_LO = PW'(RD_A);
    localparam logic [PW-1:0] A_HI = PW'(RD_A + RD_W);
    localparam logic [PW-1:0] B_LO = PW'(RD_B);
    localparam logic [PW-1:0] B_HI = PW'(RD_B + RD_W);
    localparam logic [PW-1:0] S_LO = PW'(SUB_START);
    localparam logic [PW-1:0] S_HI = PW'(SUB_START + SUB_W);

    logic [NSTEP-1:0] in_step;
    logic             is_read_line;
    logic             win_a;
    logic             win_b;

    // One pixel-range decoder per transfer step.
    for (genvar k = 0; k < NSTEP; k++) begin : g_step
        localparam logic [PW-1:0] LO = PW'(VX_START + k * VX_STEP);
        localparam logic [PW-1:0] HI = PW'(VX_START + (k + 1) * VX_STEP);
        assign in_step[k] = (pix >= LO) && (pix < HI);
    end

    // Transfer pattern choice; the readout line stays idle.
    always_comb begin
        is_read_line = (line == RD_LINE);
        v_phase      = vx_pattern(3'd0);
        if (!is_read_line) begin
            for (int k = 0; k < NSTEP; k++) begin
                if (in_step[k]) v_phase = vx_pattern(3'(k));
            end
        end
    end

    // Readout gate order by field, and the shutter drain pulse.
    always_comb begin
        win_a     = is_read_line && (pix >= A_LO) && (pix < A_HI);
        win_b     = is_read_line && (pix >= B_LO) && (pix < B_HI);
        read_p1   = fld ? win_b : win_a;
        read_p3   = fld ? win_a : win_b;
        sub_pulse = (line > RD_LINE) && (line < shut_q) &&
                    (pix >= S_LO) && (pix < S_HI);
    end

    a_r8_gates_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(read_p1 && read_p3));

    a_r8_idle_during_readout: assert property (@(posedge clk) disable iff (!rst_n)
        (read_p1 || read_p3) |-> (v_phase == 4'b0011));

    a_r7_two_or_three_phases_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(v_phase) == 2) || ($countones(v_phase) == 3));

endmodule

// File: rtl/ccd_timing_gen.sv
// Top of the CCD drive timing generator. It derives the line and field
// sizes from the region parameters and joins the horizontal counter,
// the vertical counter and the vertical drive decode.
// Assumes the vertical transfer, readout and drain windows fit in H_BLANK.
module ccd_timing_gen #(
    parameter int PH_PER_PIX = 4,
    parameter int H_BLANK    = 47,
    parameter int H_DUMMY    = 22,
    parameter int H_OBF      = 3,
    parameter int H_EFF      = 752,
    parameter int H_OBR      = 40,
    parameter int V_BLANK    = 7,
    parameter int V_OBF      = 12,
    parameter int V_EFF      = 291,
    parameter int V_OBR      = 2,
    parameter int READ_LINE  = 4,
    parameter int VX_START   = 4,
    parameter int VX_STEP    = 4,
    parameter int RD_A       = 8,
    parameter int RD_B       = 24,
    parameter int RD_W       = 8,
    parameter int SUB_START  = 38,
    parameter int SUB_W      = 4,
    localparam int LINES_ODD = V_BLANK + V_OBF + V_EFF + V_OBR,
    localparam int LW        = $clog2(LINES_ODD + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] shutter_line,
    output logic          h1,
    output logic          h2,
    output logic          rg,
    output logic          hblank,
    output logic          hd,
    output logic          vd,
    output logic          fld,
    output logic          pix_act,
    output logic          line_act,
    output logic [3:0]    v_phase,
    output logic          read_p1,
    output logic          read_p3,
    output logic          sub_pulse
);
    localparam int LINE_PIX = H_BLANK + H_DUMMY + H_OBF + H_EFF + H_OBR;
    localparam int PW       = $clog2(LINE_PIX);

    logic [PW-1:0] pix;
    logic [LW-1:0] line;
    logic [LW-1:0] shut_q;
    logic          line_end;

    ccdtg_hcount #(
        .PH_PER_PIX(PH_PER_PIX), .LINE_PIX(LINE_PIX), .H_BLANK(H_BLANK),
        .ACT_FIRST(H_BLANK + H_DUMMY + H_OBF), .H_EFF(H_EFF), .PW(PW)
    ) u_h (
        .clk(clk), .rst_n(rst_n), .pix(pix), .line_end(line_end),
        .h1(h1), .h2(h2), .rg(rg), .hblank(hblank), .hd(hd), .pix_act(pix_act)
    );

    ccdtg_vcount #(
        .LINES_ODD(LINES_ODD), .ACT_FIRST(V_BLANK + V_OBF + 1),
        .V_EFF(V_EFF), .LW(LW)
    ) u_v (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .shutter_line(shutter_line),
        .line(line), .fld(fld), .shut_q(shut_q), .vd(vd), .line_act(line_act)
    );

    ccdtg_vdrive #(
        .PW(PW), .LW(LW), .READ_LINE(READ_LINE), .VX_START(VX_START),
        .VX_STEP(VX_STEP), .RD_A(RD_A), .RD_B(RD_B), .RD_W(RD_W),
        .SUB_START(SUB_START), .SUB_W(SUB_W)
    ) u_d (
        .clk(clk), .rst_n(rst_n), .pix(pix), .line(line), .fld(fld),
        .shut_q(shut_q), .v_phase(v_phase), .read_p1(read_p1),
        .read_p3(read_p3), .sub_pulse(sub_pulse)
    );

    a_r9_drain_only_in_blanking: assert property (@(posedge clk) disable iff (!rst_n)
        sub_pulse |-> hblank);

    a_r4_line_strobe_in_blanking: assert property (@(posedge clk) disable iff (!rst_n)
        hd |-> hblank);

endmodule

// File: tb/ccd_timing_gen_test.sv
// Bench: an integer reference model of pixel, line, field and latched
// shutter, compared with every output on each clock.
module ccd_timing_gen_test;
    localparam int PH = 2, HB = 44, HDM = 2, HOF = 1, HEF = 6, HOR = 2;
    localparam int VB = 7, VOF = 2, VEF = 5, VOR = 1, RDL = 4;
    localparam int VXS = 4, VXT = 4, RA = 8, RB = 24, RW = 8, SS = 38, SW = 4;
    localparam int LP = HB + HDM + HOF + HEF + HOR;
    localparam int LODD = VB + VOF + VEF + VOR;
    localparam int LW = $clog2(LODD + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LW-1:0] shutter_line = '0;
    logic h1, h2, rg, hblank, hd, vd, fld, pix_act, line_act, read_p1, read_p3, sub_pulse;
    logic [3:0] v_phase;

    int checks = 0, failures = 0;
    int m_ph, m_pix, m_line, m_fld, m_shq;
    bit m_valid = 0;
    int n_sub = 0, n_even = 0;

    always #4 clk = ~clk;

    ccd_timing_gen #(
        .PH_PER_PIX(PH), .H_BLANK(HB), .H_DUMMY(HDM), .H_OBF(HOF), .H_EFF(HEF),
        .H_OBR(HOR), .V_BLANK(VB), .V_OBF(VOF), .V_EFF(VEF), .V_OBR(VOR),
        .READ_LINE(RDL), .VX_START(VXS), .VX_STEP(VXT), .RD_A(RA), .RD_B(RB),
        .RD_W(RW), .SUB_START(SS), .SUB_W(SW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .shutter_line(shutter_line), .h1(h1), .h2(h2),
        .rg(rg), .hblank(hblank), .hd(hd), .vd(vd), .fld(fld), .pix_act(pix_act),
        .line_act(line_act), .v_phase(v_phase), .read_p1(read_p1),
        .read_p3(read_p3), .sub_pulse(sub_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d (line %0d pix %0d fld %0d)",
                     req, act, exp, m_line, m_pix, m_fld);
        end
    endtask

    // Reference model advance, from the requirement text.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pix = 0; m_line = 1; m_fld = 0; m_shq = 0; m_valid = 1;
        end else if (m_valid) begin
            if (m_ph == PH - 1) begin
                m_ph = 0;
                if (m_pix == LP - 1) begin
                    m_pix = 0;
                    if (m_line == LODD + m_fld) begin
                        m_line = 1; m_fld = 1 - m_fld; m_shq = int'(shutter_line);
                    end else m_line++;
                end else m_pix++;
            end else m_ph++;
        end
    end

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        if (m_valid) begin
            int alo, k, b;
            bit wa, wb;
            logic [3:0] ev;
            chk(h1 == (m_ph < PH / 2), "R2 h1", h1, m_ph < PH / 2);
            chk(h2 == (m_ph >= PH / 2), "R2 h2", h2, m_ph >= PH / 2);
            chk(rg == (m_ph == 0), "R2 rg", rg, m_ph == 0);
            chk(hblank == (m_pix < HB), "R3 hblank", hblank, m_pix < HB);
            chk(pix_act == (m_pix >= HB + HDM + HOF && m_pix < HB + HDM + HOF + HEF),
                "R3 pix_act", pix_act, !pix_act);
            chk(hd == (m_pix == 0), "R4 hd", hd, m_pix == 0);
            chk(vd == (m_line == 1), "R4 vd", vd, m_line == 1);
            chk(fld == m_fld[0], "R5 fld", fld, m_fld);
            alo = VB + VOF + 1 + m_fld;
            chk(line_act == (m_line >= alo && m_line < alo + VEF), "R6 line_act",
                line_act, !line_act);
            ev = 4'b0011;
            if (m_line != RDL && m_pix >= VXS && m_pix < VXS + 8 * VXT) begin
                k = (m_pix - VXS) / VXT; b = k / 2; ev = 4'b0000;
                ev[b % 4] = 1'b1; ev[(b + 1) % 4] = 1'b1;
                if (k % 2 == 1) ev[(b + 2) % 4] = 1'b1;
            end
            chk(v_phase == ev, (m_line == RDL) ? "R8 v_phase idle" : "R7 v_phase",
                v_phase, ev);
            wa = (m_line == RDL) && m_pix >= RA && m_pix < RA + RW;
            wb = (m_line == RDL) && m_pix >= RB && m_pix < RB + RW;
            chk(read_p1 == (m_fld ? wb : wa), "R8 read_p1", read_p1, m_fld ? wb : wa);
            chk(read_p3 == (m_fld ? wa : wb), "R8 read_p3", read_p3, m_fld ? wa : wb);
            chk(sub_pulse == (m_line > RDL && m_line < m_shq && m_pix >= SS && m_pix < SS + SW),
                "R9 R10 sub_pulse", sub_pulse, !sub_pulse);
            if (sub_pulse) n_sub++;
            if (fld) n_even++;
        end
    end

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog act=1 exp=0");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen straight after release.
        chk(fld == 1'b0 && vd && hd && rg && h1 && !h2 && hblank, "R1 reset state",
            {fld, vd, hd, rg, h1, h2, hblank}, 7'b0111101);
        repeat (LP * PH * 5) @(negedge clk);
        shutter_line = LW'(10);                 // R10: mid-field change
        repeat (LP * PH * (2 * LODD + 1) * 2) @(negedge clk);
        shutter_line = LW'(20);                 // R9: beyond field end
        repeat (LP * PH * (2 * LODD + 1) * 2) @(negedge clk);
        repeat (LP * PH * 3) @(negedge clk);
        shutter_line = LW'(6);
        repeat (LP * PH * (2 * LODD + 1)) @(negedge clk);
        shutter_line = LW'(9);                  // R1 R10: reset clears latch
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (LP * PH * (2 * LODD + 1)) @(negedge clk);
        chk(n_sub > 0, "R9 drain pulses seen", n_sub, 1);
        chk(n_even > 0, "R5 even field seen", n_even, 1);
        finish_run();
    end
endmodule